// File: doc/BRIEF.md
# Automatic Level Control Gain Stepper

This block decides the gain figure that a stereo amplifier applies to its left and right channels. With level control switched off, each channel takes the gain that software selected for it through a 5-bit code. With level control switched on, the block takes a snapshot of the left code's gain and drives that one value onto both channels. It then lowers the gain by half a decibel at a time, whenever a step tick arrives while the measured output level is at or above a threshold. That threshold grows with the attenuation already applied, and a 2-bit profile sets how fast it grows. The result is a soft knee rather than a hard clamp.

Gains leave the block as signed two's-complement numbers in half-dB units, from a registered output stage. A level detector outside the block supplies the level. The gain stage downstream consumes the two outputs.

Top module: `alc_gain_stepper`

## Requirements
- R1: While reset is high, and on the first cycle after it, both gain outputs read -126 (that is, -63 dB), and no attenuation is held.
- R2: With level control off, one cycle after the codes are presented, each output equals 24 - floor((150*c + 15)/31) for its own channel's code c. Code 0 gives +12 dB (24) and code 31 gives -63 dB (-126). The channels are independent.
- R3: On the first cycle that level control is enabled, the mapped left code is captured as the preset. From the next cycle on, both outputs carry the same value, and that value starts at the preset.
- R4: While level control stays enabled, changes on either user gain code have no effect on the outputs.
- R5: While level control is enabled, a tick with level >= threshold lowers both outputs by exactly 1 (0.5 dB) on the next cycle. A tick with level < threshold leaves the gain unchanged.
- R6: The gain changes at most once per tick. With no tick, or with level control off, ticks produce no attenuation.
- R7: The gain never steps below 2 (1 dB). A preset at or below 2 is never reduced.
- R8: Threshold = base + floor(n*k), where n is the number of steps taken and k is 0, 1/4, 1/2 or 1 for profile values 0, 1, 2 and 3.
- R9: When level control is cleared, the user gains reappear on the next cycle and the step count returns to zero. A later enable therefore starts from a fresh preset and the base threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_gain_l | input | 5 | Left user gain code |
| user_gain_r | input | 5 | Right user gain code |
| alc_en | input | 1 | Level control enable |
| comp_prof | input | 2 | Compressor knee profile |
| out_level | input | 12 | Measured output peak level |
| thr_base | input | 12 | Base threshold at zero attenuation |
| step_tick | input | 1 | One-cycle permission to take a gain step |
| gain_l | output | 8 | Left gain, signed half-dB |
| gain_r | output | 8 | Right gain, signed half-dB |

## Verification
The bench holds the right code different from the left across enable. A design that captured the wrong channel, or let live codes leak through, would then split the two outputs. Each profile is checked one count below and exactly at the threshold after several steps. A design that used the step count after the increment, or rounded the slope up, would step one tick early or late. It drives the gain down into the 1 dB floor, enables with a preset already under it, and re-enables after disabling. A design that kept its stale count would start from a raised threshold and miss the first step.

// File: rtl/alc_pkg.sv
package alc_pkg;

    parameter int CODE_W  = 5;
    parameter int GAIN_W  = 8;
    parameter int LEVEL_W = 12;

    localparam int TOP_HDB  = 24;
    localparam int SPAN_HDB = 150;
    localparam int BOT_HDB  = TOP_HDB - SPAN_HDB;
    localparam int STEPS    = (1 << CODE_W) - 1;
    localparam int THR_W    = LEVEL_W + GAIN_W + 1;

    typedef logic [CODE_W-1:0]         code_t;
    typedef logic signed [GAIN_W-1:0]  hdb_t;
    typedef logic [GAIN_W-1:0]         atten_t;
    typedef logic [LEVEL_W-1:0]        level_t;
    typedef logic [THR_W-1:0]          thr_t;

    localparam hdb_t FLOOR_HDB = hdb_t'(2);
    localparam hdb_t RESET_HDB = hdb_t'(BOT_HDB);

    typedef enum logic [1:0] {
        PROF_FLAT    = 2'd0,
        PROF_QUARTER = 2'd1,
        PROF_HALF    = 2'd2,
        PROF_FULL    = 2'd3
    } prof_e;

    typedef struct packed {
        logic   active;
        hdb_t   preset;
        atten_t atten;
    } alc_state_t;

    // Evenly spread the user codes over the span, rounded to the nearest half dB.
    function automatic hdb_t code_to_hdb(input code_t c);
        int drop;
        drop = (int'(c) * SPAN_HDB + STEPS / 2) / STEPS;
        return hdb_t'(TOP_HDB - drop);
    endfunction

    // Threshold grows with the step count at the profile's slope.
    function automatic thr_t knee_threshold(input level_t base, input atten_t n, input prof_e p);
        atten_t inc;
        case (p)
            PROF_FLAT:    inc = '0;
            PROF_QUARTER: inc = n >> 2;
            PROF_HALF:    inc = n >> 1;
            default:      inc = n;
        endcase
        return {{(THR_W-LEVEL_W){1'b0}}, base} + {{(THR_W-GAIN_W){1'b0}}, inc};
    endfunction

endpackage

// File: rtl/alc_code_map.sv
module alc_code_map
    import alc_pkg::*;
(
    input  code_t code,
    output hdb_t  hdb
);
    assign hdb = code_to_hdb(code);
endmodule

// File: rtl/alc_knee_thresh.sv
module alc_knee_thresh
    import alc_pkg::*;
(
    input  level_t level,
    input  level_t base,
    input  atten_t atten,
    input  prof_e  prof,
    output logic   at_thresh
);
    thr_t thr;
    thr_t level_ext;

    always_comb begin
        thr       = knee_threshold(base, atten, prof);
        level_ext = {{(THR_W-LEVEL_W){1'b0}}, level};
        at_thresh = (level_ext >= thr);
    end
endmodule

// File: rtl/alc_atten_ctrl.sv
module alc_atten_ctrl
    import alc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   tick,
    input  logic   at_thresh,
    input  hdb_t   preset_in,
    output atten_t atten_q,
    output logic   nxt_active,
    output hdb_t   nxt_gain
);
    alc_state_t st, nxt;
    hdb_t       cur_gain;

    always_comb begin
        cur_gain = st.preset - hdb_t'(st.atten);
        nxt      = st;
        if (!en) begin
            nxt.active = 1'b0;
            nxt.atten  = '0;
        end else if (!st.active) begin
            nxt.active = 1'b1;
            nxt.preset = preset_in;
            nxt.atten  = '0;
        end else if (tick && at_thresh && (cur_gain > FLOOR_HDB)) begin
            nxt.atten = st.atten + atten_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{active: 1'b0, preset: '0, atten: '0};
        end else begin
            st <= nxt;
        end
    end

    assign atten_q    = st.atten;
    assign nxt_active = nxt.active;
    assign nxt_gain   = nxt.preset - hdb_t'(nxt.atten);
endmodule

// File: rtl/alc_gain_stepper.sv
module alc_gain_stepper
    import alc_pkg::*;
#(
    parameter int NUM_CH = 2
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CODE_W-1:0]         user_gain_l,
    input  logic [CODE_W-1:0]         user_gain_r,
    input  logic                      alc_en,
    input  logic [1:0]                comp_prof,
    input  logic [LEVEL_W-1:0]        out_level,
    input  logic [LEVEL_W-1:0]        thr_base,
    input  logic                      step_tick,
    output logic signed [GAIN_W-1:0]  gain_l,
    output logic signed [GAIN_W-1:0]  gain_r
);
    code_t  user_codes [NUM_CH];
    hdb_t   mapped     [NUM_CH];
    hdb_t   gain_q     [NUM_CH];
    atten_t atten_q;
    logic   at_thresh;
    logic   nxt_active;
    hdb_t   nxt_gain;

    assign user_codes[0] = user_gain_l;
    assign user_codes[1] = user_gain_r;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_map
        alc_code_map u_map (
            .code (user_codes[ch]),
            .hdb  (mapped[ch])
        );
    end

    alc_knee_thresh u_knee (
        .level     (out_level),
        .base      (thr_base),
        .atten     (atten_q),
        .prof      (prof_e'(comp_prof)),
        .at_thresh (at_thresh)
    );

    alc_atten_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .en         (alc_en),
        .tick       (step_tick),
        .at_thresh  (at_thresh),
        .preset_in  (mapped[0]),
        .atten_q    (atten_q),
        .nxt_active (nxt_active),
        .nxt_gain   (nxt_gain)
    );

    // The locked left preset drives every channel while control is active.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                gain_q[ch] <= RESET_HDB;
            end else if (nxt_active) begin
                gain_q[ch] <= nxt_gain;
            end else begin
                gain_q[ch] <= mapped[ch];
            end
        end
    end

    assign gain_l = gain_q[0];
    assign gain_r = gain_q[1];
endmodule

// File: rtl/alc_gain_stepper_chk.sv
module alc_gain_stepper_chk
    import alc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CODE_W-1:0]         user_gain_l,
    input  logic [CODE_W-1:0]         user_gain_r,
    input  logic                      alc_en,
    input  logic                      step_tick,
    input  logic signed [GAIN_W-1:0]  gain_l,
    input  logic signed [GAIN_W-1:0]  gain_r
);
    logic en_d;

    always_ff @(posedge clk) begin
        if (rst) en_d <= 1'b0;
        else     en_d <= alc_en;
    end

    a_r3_both_track: assert property (@(posedge clk) disable iff (rst)
        alc_en |=> (gain_l == gain_r));

    a_r9_user_restore: assert property (@(posedge clk) disable iff (rst)
        !alc_en |=> (gain_l == code_to_hdb($past(user_gain_l)) &&
                     gain_r == code_to_hdb($past(user_gain_r))));

    // R4 and R6: an enabled cycle without a tick holds the gain
    a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (alc_en && en_d && !step_tick) |=> $stable(gain_l));

    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        (alc_en && en_d) |=> (gain_l == $past(gain_l) ||
                              hdb_t'(gain_l + hdb_t'(1)) == $past(gain_l)));

    a_r7_floor: assert property (@(posedge clk) disable iff (rst)
        (alc_en && en_d && gain_l <= FLOOR_HDB) |=> $stable(gain_l));

endmodule

bind alc_gain_stepper alc_gain_stepper_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .user_gain_l (user_gain_l),
    .user_gain_r (user_gain_r),
    .alc_en      (alc_en),
    .step_tick   (step_tick),
    .gain_l      (gain_l),
    .gain_r      (gain_r)
);

// File: tb/alc_gain_stepper_tb.sv
`timescale 1ns/1ps
module alc_gain_stepper_tb;
    localparam int PERIOD = 4;
    localparam int NV = 6;
    // user_l, user_r, expected_l, expected_r (half-dB)
    localparam int VEC [NV][4] = '{
        '{0, 31, 24, -126},
        '{1, 16, 19, -53},
        '{5, 10, 0, -24},
        '{3, 20, 9, -73},
        '{27, 2, -107, 14},
        '{4, 0, 5, 24}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic [4:0]        user_gain_l, user_gain_r;
    logic              alc_en, step_tick;
    logic [1:0]        comp_prof;
    logic [11:0]       out_level, thr_base;
    logic signed [7:0] gain_l, gain_r;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    alc_gain_stepper u_dut (
        .clk(clk), .rst(rst), .user_gain_l(user_gain_l), .user_gain_r(user_gain_r),
        .alc_en(alc_en), .comp_prof(comp_prof), .out_level(out_level),
        .thr_base(thr_base), .step_tick(step_tick), .gain_l(gain_l), .gain_r(gain_r)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int el, input int er);
        n_checks++;
        if (int'(gain_l) != el || int'(gain_r) != er) begin
            n_fail++;
            $display("FAIL %s: got l=%0d r=%0d expected l=%0d r=%0d", req, gain_l, gain_r, el, er);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; user_gain_l = 5'd0; user_gain_r = 5'd0; alc_en = 1'b0;
        step_tick = 1'b0; comp_prof = 2'd0; out_level = '0; thr_base = '0;
        @(negedge clk); cyc(); cyc();
        chk("R1 reset value", -126, -126);
        rst = 1'b0;

        // R2: table of independent per-channel mappings
        for (int i = 0; i < NV; i++) begin
            user_gain_l = 5'(VEC[i][0]);
            user_gain_r = 5'(VEC[i][1]);
            cyc();
            chk("R2 map", VEC[i][2], VEC[i][3]);
        end

        // R3 capture of left preset
        user_gain_l = 5'd0; user_gain_r = 5'd31; thr_base = 12'd100;
        alc_en = 1'b1;
        cyc(); chk("R3 capture left", 24, 24);
        // R4 writes ignored
        user_gain_l = 5'd31; user_gain_r = 5'd0;
        cyc(); chk("R4 writes ignored", 24, 24);

        // R5 below and at threshold
        out_level = 12'd99; step_tick = 1'b1;
        cyc(); chk("R5 below threshold", 24, 24);
        out_level = 12'd100;
        cyc(); chk("R5 at threshold", 23, 23);
        step_tick = 1'b0;
        cyc(); chk("R6 no tick", 23, 23);
        step_tick = 1'b1;
        cyc(); chk("R6 one per tick a", 22, 22);
        cyc(); chk("R6 one per tick b", 21, 21);

        // R8 profiles, n = 3
        comp_prof = 2'd3; out_level = 12'd102;
        cyc(); chk("R8 full below", 21, 21);
        out_level = 12'd103;
        cyc(); chk("R8 full at", 20, 20);
        comp_prof = 2'd1; out_level = 12'd100;
        cyc(); chk("R8 quarter below", 20, 20);
        out_level = 12'd101;
        cyc(); chk("R8 quarter at", 19, 19);
        comp_prof = 2'd2; out_level = 12'd101;
        cyc(); chk("R8 half below", 19, 19);
        out_level = 12'd102;
        cyc(); chk("R8 half at", 18, 18);
        step_tick = 1'b0;

        // R9 restore and fresh count
        alc_en = 1'b0; user_gain_l = 5'd31; user_gain_r = 5'd0;
        cyc(); chk("R9 restore", -126, 24);
        alc_en = 1'b1; user_gain_l = 5'd1;
        cyc(); chk("R9 re-enable preset", 19, 19);
        comp_prof = 2'd3; out_level = 12'd100; step_tick = 1'b1;
        cyc(); chk("R9 count cleared", 18, 18);
        step_tick = 1'b0;

        // R7 floor
        alc_en = 1'b0; user_gain_l = 5'd4;
        cyc(); chk("R7 setup", 5, 24);
        alc_en = 1'b1;
        cyc(); chk("R7 preset", 5, 5);
        thr_base = 12'd0; out_level = 12'hFFF; comp_prof = 2'd0; step_tick = 1'b1;
        cyc(); chk("R7 step 4", 4, 4);
        cyc(); chk("R7 step 3", 3, 3);
        cyc(); chk("R7 step 2", 2, 2);
        cyc(); chk("R7 floor hold", 2, 2);
        step_tick = 1'b0; alc_en = 1'b0; user_gain_l = 5'd5;
        cyc(); chk("R7 low setup", 0, 24);
        alc_en = 1'b1; step_tick = 1'b1;
        cyc(); chk("R7 low preset", 0, 0);
        cyc(); chk("R7 low preset held", 0, 0);

        // R6 ticks while disabled
        alc_en = 1'b0; user_gain_l = 5'd10; user_gain_r = 5'd3;
        cyc(); chk("R6 disabled tick a", -24, 9);
        cyc(); chk("R6 disabled tick b", -24, 9);
        step_tick = 1'b0;

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule